// File: doc/BRIEF.md
# I2C Serial Memory Slave Engine

This block is the protocol side of a 4K x 8 serial memory that answers on a two-wire I2C bus. It runs on a fast system clock. It passes the SCL and SDA lines through a short synchronizer and finds clock edges, start conditions and stop conditions relative to that clock. It receives bytes MSB first and sends them MSB first. It answers by pulling SDA low through an active-high pull enable. It never drives the line high.

A transaction opens with a select byte. The select byte holds the device type 1010 in bits 7..4, a three-bit chip code in bits 3..1 and the direction in bit 0, where 1 means read. For a write, two address bytes follow, then data bytes. Accepted data bytes are staged in a one-page buffer. A stop after a data byte's acknowledge slot commits the buffer to the array and starts a timed write cycle. The memory is a flat register array in this model. Reads stream bytes from an internal pointer. A random read loads that pointer with a write header and then a repeated start.

The engine has eleven named states. IDLE is standby. SEL, AHI, ALO and WDAT receive the select byte, the high address byte, the low address byte and the data bytes. SEL_ACK, AHI_ACK, ALO_ACK and WDAT_ACK are the acknowledge slots that follow each of those bytes. RDAT shifts a byte out. RDAT_MACK waits for the master's acknowledge. A start moves the engine to SEL, or to IDLE while the write cycle is busy. A stop moves it to IDLE. At the SCL fall that ends a received byte, each receive state moves to its acknowledge state. The one exception is SEL with a mismatching select byte, which returns to IDLE. At the next fall the acknowledge states move on as follows:
- SEL_ACK goes to RDAT or AHI, depending on the direction bit.
- AHI_ACK goes to ALO.
- ALO_ACK goes to WDAT.
- WDAT_ACK goes to WDAT.

RDAT moves to RDAT_MACK after its eighth bit. RDAT_MACK returns to RDAT on an acknowledge and to IDLE on a missing acknowledge.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: SDA is only ever pulled low through `sda_pull_o`. The pull is released during reset and in standby.
- R2: A select byte is acknowledged only when bits 7..4 are 1010 and bits 3..1 equal `chip_sel_i`. Any other select byte gets no acknowledge, and the engine returns to standby.
- R3: After a write select, two address bytes are acknowledged, high byte first. Only the low 12 address bits are used, so the upper four bits of the high byte have no effect.
- R4: Each acknowledged data byte is written at the pointer, and the pointer then advances within its 32-byte page. Address bits 11..5 stay fixed, so bytes past the page end overwrite the start of the page. The bytes reach the array only when a stop follows the acknowledge slot of a data byte.
- R5: With `wprot_i` high, the select and address bytes are still acknowledged. Every data byte gets no acknowledge, and the array is left unchanged.
- R6: A write header followed by a repeated start and a read select returns the byte at the loaded address.
- R7: While the master acknowledges, reads stream consecutive bytes, and the pointer wraps from 0xFFF to 0x000. A read select without an address continues from the pointer. A missing master acknowledge ends the read and releases SDA.
- R8: After a commit, the engine acknowledges nothing for WR_CYCLES system clocks, not even a matching select byte. After that it answers again.
- R9: A start or repeated start aborts any partial byte and waits for a select byte. A stop that does not follow a data byte's acknowledge slot commits nothing and starts no write cycle.
- R10: Reads behave the same whatever the level of `wprot_i`.
- R11: SDA is sampled on rising SCL. The pull is asserted only right after a falling SCL edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | 1 pulls SDA low; 0 releases it |
| chip_sel_i | input | 3 | Strap value compared with select bits 3..1 |
| wprot_i | input | 1 | Write protect; 1 refuses data bytes |

## Verification
The end of the internal write cycle and the detection of a new start condition can land in the same system clock cycle. The bench provokes this with a sweep. After each single-byte write, it issues a start at a delay measured from the stop that differs by a few clocks from one pass to the next, so the polling select lands on both sides of the write cycle's end. A select that starts well before the cycle ends must get no acknowledge. One that starts well after must be acknowledged. A narrow band around the edge, caused by synchronizer latency, is accepted either way.

// File: rtl/eeprom_i2c_pkg.sv
package eeprom_i2c_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SEL,
        ST_SEL_ACK,
        ST_AHI,
        ST_AHI_ACK,
        ST_ALO,
        ST_ALO_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RDAT_MACK
    } eng_state_t;

    localparam logic [3:0] DEV_TYPE = 4'b1010;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic              scl_d, sda_d;
    logic              scl_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_now    = scl_pipe[STAGES-1];
    assign sda_o      = sda_pipe[STAGES-1];
    assign scl_rise_o = scl_now & ~scl_d;
    assign scl_fall_o = ~scl_now & scl_d;
    assign start_o    = scl_now & scl_d & sda_d & ~sda_o;
    assign stop_o     = scl_now & scl_d & ~sda_d & sda_o;

endmodule

// File: rtl/eeprom_page_store.sv
module eeprom_page_store #(
    parameter int ADDR_W    = 12,
    parameter int PAGE_W    = 5,
    parameter int WR_CYCLES = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stage_we_i,
    input  logic [ADDR_W-1:0] stage_addr_i,
    input  logic [7:0]        stage_data_i,
    input  logic              discard_i,
    input  logic              commit_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [7:0]        rd_data_o,
    output logic              busy_o
);
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int CNT_W      = $clog2(WR_CYCLES + 1);

    logic [7:0]               mem  [DEPTH];
    logic [7:0]               pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0]    pmask_q;
    logic [ADDR_W-PAGE_W-1:0] page_q;
    logic [CNT_W-1:0]         cnt_q;
    logic                     do_commit;

    assign busy_o    = (cnt_q != '0);
    assign do_commit = commit_i && !busy_o && (pmask_q != '0);
    assign rd_data_o = mem[rd_addr_i];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pmask_q <= '0;
            page_q  <= '0;
            cnt_q   <= '0;
        end else begin
            if (commit_i || discard_i) begin
                pmask_q <= '0;
            end else if (stage_we_i) begin
                pmask_q[stage_addr_i[PAGE_W-1:0]] <= 1'b1;
                page_q <= stage_addr_i[ADDR_W-1:PAGE_W];
            end
            if (do_commit) begin
                cnt_q <= CNT_W'(WR_CYCLES);
            end else if (busy_o) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (stage_we_i) begin
            pbuf[stage_addr_i[PAGE_W-1:0]] <= stage_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (do_commit) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (pmask_q[i]) begin
                    mem[{page_q, PAGE_W'(i)}] <= pbuf[i];
                end
            end
        end
    end

    // R8: the engine never asks for a commit while a cycle is running
    p_commit_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |-> !busy_o);

    // R8: a write cycle only ever begins from a commit request
    p_busy_from_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(commit_i));

endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave
    import eeprom_i2c_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int PAGE_W      = 5,
    parameter int WR_CYCLES   = 200,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    input  logic [2:0] chip_sel_i,
    input  logic       wprot_i
);
    localparam int AHI_W = ADDR_W - 8;

    logic sda_s, scl_rise, scl_fall, start_s, stop_s;
    logic busy;
    logic [7:0] rd_data;

    eng_state_t        state_q, state_d;
    logic [3:0]        bit_q;
    logic [7:0]        sh_q;
    logic [7:0]        tx_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [AHI_W-1:0]  ahi_q;
    logic              ack_q;
    logic              mack_q;

    logic byte_done, sel_match, rx_state;
    logic stage_we, commit, discard;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_in     (scl_i),
        .sda_in     (sda_i),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_s),
        .stop_o     (stop_s)
    );

    eeprom_page_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .stage_we_i   (stage_we),
        .stage_addr_i (ptr_q),
        .stage_data_i (sh_q),
        .discard_i    (discard),
        .commit_i     (commit),
        .rd_addr_i    (ptr_q),
        .rd_data_o    (rd_data),
        .busy_o       (busy)
    );

    assign byte_done = (bit_q == 4'd8);
    assign sel_match = (sh_q[7:4] == DEV_TYPE) && (sh_q[3:1] == chip_sel_i);
    assign rx_state  = (state_q == ST_SEL) || (state_q == ST_AHI) ||
                       (state_q == ST_ALO) || (state_q == ST_WDAT);

    // next state and strobes
    always_comb begin
        state_d  = state_q;
        stage_we = 1'b0;
        commit   = 1'b0;
        discard  = 1'b0;
        if (start_s) begin
            state_d = busy ? ST_IDLE : ST_SEL;
            discard = 1'b1;
        end else if (stop_s) begin
            state_d = ST_IDLE;
            commit  = (state_q == ST_WDAT) && (bit_q <= 4'd1);
            discard = !commit;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_SEL: if (scl_fall && byte_done)
                            state_d = sel_match ? ST_SEL_ACK : ST_IDLE;
                ST_AHI: if (scl_fall && byte_done) state_d = ST_AHI_ACK;
                ST_ALO: if (scl_fall && byte_done) state_d = ST_ALO_ACK;
                ST_WDAT: if (scl_fall && byte_done) begin
                            state_d  = ST_WDAT_ACK;
                            stage_we = !wprot_i;
                         end
                ST_SEL_ACK:  if (scl_fall) state_d = sh_q[0] ? ST_RDAT : ST_AHI;
                ST_AHI_ACK:  if (scl_fall) state_d = ST_ALO;
                ST_ALO_ACK:  if (scl_fall) state_d = ST_WDAT;
                ST_WDAT_ACK: if (scl_fall) state_d = ST_WDAT;
                ST_RDAT:     if (scl_fall && bit_q == 4'd7) state_d = ST_RDAT_MACK;
                ST_RDAT_MACK: if (scl_fall) state_d = mack_q ? ST_RDAT : ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
            sh_q    <= '0;
            tx_q    <= '0;
            ptr_q   <= '0;
            ahi_q   <= '0;
            ack_q   <= 1'b0;
            mack_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start_s || stop_s) begin
                bit_q <= '0;
                ack_q <= 1'b0;
            end else if (rx_state) begin
                if (scl_rise) begin
                    sh_q  <= {sh_q[6:0], sda_s};
                    bit_q <= bit_q + 4'd1;
                end else if (scl_fall && byte_done) begin
                    bit_q <= '0;
                    unique case (state_q)
                        ST_SEL:  ack_q <= sel_match;
                        ST_AHI:  begin ack_q <= 1'b1; ahi_q <= sh_q[AHI_W-1:0]; end
                        ST_ALO:  begin ack_q <= 1'b1; ptr_q <= {ahi_q, sh_q}; end
                        default: begin
                            ack_q <= !wprot_i;
                            if (!wprot_i)
                                ptr_q <= {ptr_q[ADDR_W-1:PAGE_W],
                                          ptr_q[PAGE_W-1:0] + PAGE_W'(1)};
                        end
                    endcase
                end
            end else if (state_q == ST_RDAT) begin
                if (scl_fall) begin
                    if (bit_q == 4'd7) begin
                        bit_q <= '0;
                        ptr_q <= ptr_q + ADDR_W'(1);
                    end else begin
                        bit_q <= bit_q + 4'd1;
                        tx_q  <= {tx_q[6:0], 1'b0};
                    end
                end
            end else if (state_q == ST_RDAT_MACK) begin
                if (scl_rise) mack_q <= !sda_s;
                if (scl_fall && mack_q) tx_q <= rd_data;
            end else if (state_q != ST_IDLE) begin
                if (scl_fall) begin
                    ack_q <= 1'b0;
                    bit_q <= '0;
                    if (state_q == ST_SEL_ACK && sh_q[0]) tx_q <= rd_data;
                end
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_SEL_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_WDAT_ACK: sda_pull_o = ack_q;
            ST_RDAT: sda_pull_o = ~tx_q[7];
            default: sda_pull_o = 1'b0;
        endcase
    end

    // R11: the pull only starts right after a falling SCL edge
    p_pull_after_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> $past(scl_fall));

    // R8: nothing is acknowledged while the write cycle runs
    p_silent_while_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_pull_o);

    // R9: a start while idle of writes always leads to select reception
    p_start_to_select_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_s && !busy) |=> (state_q == ST_SEL));

    // R2: a foreign select byte returns the engine to standby, line released
    p_mismatch_standby_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEL && scl_fall && byte_done && !sel_match && !start_s && !stop_s)
        |=> (state_q == ST_IDLE && !sda_pull_o));

    // R5: protected data bytes are never acknowledged
    p_wp_no_data_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WDAT && scl_fall && byte_done && wprot_i && !start_s && !stop_s)
        |=> !sda_pull_o);

    // R7: the read pointer wraps at the top of the array
    p_read_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RDAT && scl_fall && bit_q == 4'd7 && ptr_q == '1 && !start_s && !stop_s)
        |=> (ptr_q == '0));

endmodule

// File: tb/sim_eeprom_i2c_slave.sv
module sim_eeprom_i2c_slave;
    localparam int CLK_P  = 10;
    localparam int Q      = 5;
    localparam int WR     = 200;
    localparam logic [2:0] STRAP = 3'b101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic wp = 1'b0;
    logic sda_pull;
    wire  sda_line = sda_m & ~sda_pull;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [4096];

    always #(CLK_P/2) clk = ~clk;

    eeprom_i2c_slave #(.WR_CYCLES(WR)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_pull_o (sda_pull),
        .chip_sel_i (STRAP),
        .wprot_i    (wp)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw();
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); b = sda_line; qw(); scl_m = 1'b0; qw();
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        ack = !b;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(!mack);
    endtask

    // write header: select + two address bytes, each must be acknowledged
    task automatic header(input logic [11:0] a, input logic [3:0] junk, input string req);
        logic ack;
        i2c_start();
        send_byte({4'b1010, STRAP, 1'b0}, ack); chk({req, " select ack"}, ack, 1);
        send_byte({junk, a[11:8]}, ack);         chk({req, " addr hi ack"}, ack, 1);
        send_byte(a[7:0], ack);                  chk({req, " addr lo ack"}, ack, 1);
    endtask

    task automatic wr_seq(input logic [11:0] a, input int n, input int seed, input logic [3:0] junk);
        logic ack;
        header(a, junk, "R3");
        for (int k = 0; k < n; k++) begin
            send_byte(pat(seed + k), ack);
            chk(wp ? "R5 data nack" : "R4 data ack", ack, wp ? 0 : 1);
            if (!wp) model[{a[11:5], 5'((a[4:0] + k) % 32)}] = pat(seed + k);
        end
        i2c_stop();
        if (!wp) repeat (WR + 20) @(negedge clk);
    endtask

    task automatic rd_random(input logic [11:0] a, input int n, input string req);
        logic ack;
        logic [7:0] v;
        header(a, 4'h0, req);
        i2c_start();
        send_byte({4'b1010, STRAP, 1'b1}, ack); chk({req, " read select ack"}, ack, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, v);
            chk({req, " read data"}, v, model[12'((a + k) & 12'hFFF)]);
        end
        chk({req, " released after nack"}, sda_pull, 0);
        i2c_stop();
    endtask

    task automatic poll_ack(output logic ack);
        i2c_start();
        send_byte({4'b1010, STRAP, 1'b0}, ack);
        i2c_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] v;
        logic b;
        repeat (5) @(negedge clk);
        chk("R1 pull released in reset", sda_pull, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 pull released in standby", sda_pull, 0);

        // R2: chip code sweep, then device type sweep
        for (int c = 0; c < 8; c++) begin
            i2c_start();
            send_byte({4'b1010, 3'(c), 1'b0}, ack);
            chk("R2 chip code match", ack, (3'(c) == STRAP) ? 1 : 0);
            chk("R2 standby after select", sda_pull, 0);
            i2c_stop();
        end
        for (int t = 0; t < 16; t++) begin
            i2c_start();
            send_byte({4'(t), STRAP, 1'b1}, ack);
            chk("R2 type code match", ack, (t == 10) ? 1 : 0);
            if (ack) begin
                recv_byte(1'b0, v);
            end
            i2c_stop();
        end

        // R4 byte writes; R3 upper address bits ignored
        wr_seq(12'h123, 1, 1, 4'h0);
        wr_seq(12'h140, 1, 2, 4'hA);
        wr_seq(12'h150, 1, 3, 4'h0);
        wr_seq(12'h300, 1, 4, 4'h0);
        rd_random(12'h123, 1, "R6");
        rd_random(12'h140, 1, "R3");
        rd_random(12'h150, 1, "R6");

        // R4 page write with roll-over, read back whole page
        wr_seq(12'h23E, 34, 40, 4'h0);
        rd_random(12'h220, 32, "R4");

        // R5 write protect: header acked, data refused, array untouched
        wp = 1'b1;
        wr_seq(12'h300, 3, 90, 4'h0);
        poll_ack(ack);
        chk("R5 no write cycle started", ack, 1);
        rd_random(12'h300, 1, "R5");
        rd_random(12'h220, 4, "R10");
        wp = 1'b0;

        // R7 sequential read across the wrap, then current address read
        wr_seq(12'hFFE, 2, 120, 4'h0);
        wr_seq(12'h000, 3, 130, 4'h0);
        rd_random(12'hFFE, 4, "R7");
        i2c_start();
        send_byte({4'b1010, STRAP, 1'b1}, ack);
        chk("R7 current read select ack", ack, 1);
        recv_byte(1'b0, v);
        chk("R7 current read data", v, model[12'h002]);
        i2c_stop();

        // R9 repeated start mid data byte aborts the write
        header(12'h150, 4'h0, "R9");
        for (int i = 0; i < 4; i++) put_bit(1'b0);
        i2c_start();
        send_byte({4'b1010, STRAP, 1'b1}, ack);
        chk("R9 read after abort ack", ack, 1);
        recv_byte(1'b0, v);
        chk("R9 data unchanged after abort", v, model[12'h150]);
        i2c_stop();
        poll_ack(ack);
        chk("R9 no write cycle after abort", ack, 1);

        // R9 stop mid data byte commits nothing
        header(12'h150, 4'h0, "R9");
        for (int i = 0; i < 4; i++) put_bit(1'b0);
        i2c_stop();
        poll_ack(ack);
        chk("R9 no write cycle after early stop", ack, 1);
        rd_random(12'h150, 1, "R9");

        // R8 write cycle end against start detection sweep
        for (int d = WR - 10; d <= WR + 10; d += 2) begin
            header(12'h400 + 12'(d), 4'h0, "R8");
            send_byte(pat(d), ack);
            chk("R8 data ack", ack, 1);
            model[12'h400 + 12'(d)] = pat(d);
            i2c_stop();
            repeat (d) @(negedge clk);
            sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
            send_byte({4'b1010, STRAP, 1'b0}, ack);
            if (d < WR - 4) chk("R8 select refused while busy", ack, 0);
            else if (d > WR + 4) chk("R8 select answered after cycle", ack, 1);
            i2c_stop();
            repeat (WR + 20) @(negedge clk);
        end
        rd_random(12'h400 + 12'(WR - 10), 1, "R8");

        // R11 single-bit check: no pull while SCL high on a released slot
        get_bit(b);
        chk("R11 idle line high", b, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule